// File: doc/BRIEF.md
# Dual-Issue In-Order Scheduler with Shared Execution Units

This block decides, every cycle, which of the two oldest decoded instructions may enter execute. Both issue slots draw on one pool of four execution units: a multiplier, an adder, a logic unit and a load unit. Each unit accepts one new operation per cycle. The block admits an instruction only when three conditions hold. Its operands and its destination are free of in-flight work. Its unit is not already taken by the older slot. A result-store port will be free in the cycle the instruction completes. Issue is strictly in order, so the younger slot never overtakes a blocked older slot.

A per-register scoreboard holds a busy flag and a countdown. A load keeps its destination unavailable for two cycles and any other operation for one. When a countdown expires, the register is reported on one of two writeback ports. Each port is given to whichever completing result needs it. A small booking table records how many results are due in each of the next few cycles. It keeps the completions in any one cycle within the two ports. The queue feeding the block advances by the number of grants.

Top module: `sched_dual_issue`

## Requirements
- R1: After reset every register is ready, no writeback is reported, and an instruction in slot 0 is granted in the first cycle after reset.
- R2: Unit codes are 0 multiplier, 1 adder, 2 logic unit, 3 load unit. A granted slot raises bit `code` of its four-bit unit select, and a slot that is not granted shows all zeros.
- R3: If an instruction issues in cycle t, a dependent instruction may issue in cycle t+2 when the producer is a load, and in cycle t+1 otherwise.
- R4: An instruction whose sources or destination are still counting down from in-flight work is not granted.
- R5: Slot 1 is not granted when either of its sources or its destination equals the destination of slot 0.
- R6: When both slots need the same unit, slot 0 is granted and slot 1 waits. Different units may issue together.
- R7: Slot 1 is never granted in a cycle where slot 0 is not granted.
- R8: A result is reported during its completion cycle, which is the issue cycle plus its latency. At most two results are reported per cycle. Port 0 carries the lower register number, and port 1 is used only when port 0 is.
- R9: An instruction is not granted if two results are already due in its completion cycle, counting an older grant of the same cycle.
- R10: The stall output is high exactly when a valid slot that is eligible for issue is not granted.
- R11: A load, an add that depends on the load, a subtract on the adder and an independent multiply issue at relative cycles 0, 2, 3 and 3.
- R12: A slot 1 instruction presented without a valid slot 0 is ignored. It gets no grant and no stall, and it has no later writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 2 | Slot valid; bit 0 is the older slot |
| in_unit | input | 2x2 | Unit code per slot |
| in_dst | input | 2xRW | Destination register per slot |
| in_srca | input | 2xRW | First source register per slot |
| in_srcb | input | 2xRW | Second source register per slot |
| iss_gnt | output | 2 | Issue grant per slot |
| iss_unit | output | 2x4 | One-hot unit select per slot |
| iss_stall | output | 1 | A valid eligible slot is held back |
| wb_vld | output | 2 | Writeback port valid |
| wb_reg | output | 2xRW | Register completing on each writeback port |

## Verification
Grants, unit selects and stall are combinational in the current inputs and scoreboard state. The bench samples them in the same cycle the slots are presented, shortly before the clock edge. A result is due on a writeback port exactly its latency after the edge that granted it: one cycle for ordinary operations and two for loads. The behavioural model stores, for each register, the absolute cycle in which its result is due. It predicts the writeback ports from those cycles and compares them every cycle. The directed sequences record the cycle in which each instruction was actually granted. They then compare the distances between grants with the hand-derived issue schedules.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int NSLOT = 2;
  localparam int NWBP  = 2;
  localparam int NUNIT = 4;

  typedef enum logic [1:0] {
    U_MUL   = 2'd0,
    U_ADD   = 2'd1,
    U_LOGIC = 2'd2,
    U_LOAD  = 2'd3
  } unit_e;

endpackage

// File: rtl/sched_scoreboard.sv
module sched_scoreboard
  import sched_pkg::*;
#(
  parameter int NREG = 16,
  parameter int RW   = 4,
  parameter int CW   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSLOT-1:0]          set_en,
  input  logic [NSLOT-1:0][RW-1:0]  set_reg,
  input  logic [NSLOT-1:0][CW-1:0]  set_cnt,
  output logic [NREG-1:0]           rdy,
  output logic [NREG-1:0]           done
);

  for (genvar r = 0; r < NREG; r++) begin : g_ent
    logic          busy_q, busy_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hit0, hit1, ent_en;

    // next state of one entry: a new grant wins over the countdown
    always_comb begin
      hit0   = set_en[0] && (set_reg[0] == RW'(r));
      hit1   = set_en[1] && (set_reg[1] == RW'(r));
      busy_d = busy_q;
      cnt_d  = cnt_q;
      if (hit0) begin
        busy_d = 1'b1;
        cnt_d  = set_cnt[0];
      end else if (hit1) begin
        busy_d = 1'b1;
        cnt_d  = set_cnt[1];
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end

    assign ent_en = hit0 | hit1 | busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (ent_en) begin
        busy_q <= busy_d;
        cnt_q  <= cnt_d;
      end
    end

    assign rdy[r]  = !busy_q || (cnt_q == '0);
    assign done[r] = busy_q && (cnt_q == '0);
  end

endmodule

// File: rtl/sched_wb_book.sv
module sched_wb_book
  import sched_pkg::*;
#(
  parameter int MAXLAT = 2,
  parameter int CW     = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSLOT-1:0]          gnt,
  input  logic [NSLOT-1:0][CW-1:0]  glat,
  output logic [MAXLAT:1][1:0]      book
);

  logic [MAXLAT:1][1:0]   book_q, book_d;
  logic [MAXLAT+1:1][1:0] book_ext;
  logic                   book_en;

  assign book_ext = {2'b00, book_q};

  // entry k counts results due k cycles ahead; it shifts down each cycle
  always_comb begin
    for (int k = 1; k <= MAXLAT; k++) begin
      logic [1:0] add;
      add = 2'(gnt[0] && (glat[0] == CW'(k + 1)))
          + 2'(gnt[1] && (glat[1] == CW'(k + 1)));
      book_d[k] = book_ext[k + 1] + add;
    end
  end

  assign book_en = (|gnt) || (book_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      book_q <= '0;
    end else if (book_en) begin
      book_q <= book_d;
    end
  end

  assign book = book_q;

endmodule

// File: rtl/sched_wb_pick.sv
module sched_wb_pick
  import sched_pkg::*;
#(
  parameter int NREG = 16,
  parameter int RW   = 4
) (
  input  logic [NREG-1:0]          done,
  output logic [NWBP-1:0]          wb_vld,
  output logic [NWBP-1:0][RW-1:0]  wb_reg
);

  // lowest completing register to port 0, next one to port 1
  always_comb begin
    wb_vld = '0;
    wb_reg = '0;
    for (int r = 0; r < NREG; r++) begin
      if (done[r]) begin
        if (!wb_vld[0]) begin
          wb_vld[0] = 1'b1;
          wb_reg[0] = RW'(r);
        end else if (!wb_vld[1]) begin
          wb_vld[1] = 1'b1;
          wb_reg[1] = RW'(r);
        end
      end
    end
  end

endmodule

// File: rtl/sched_issue_ctl.sv
module sched_issue_ctl
  import sched_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int RW     = 4,
  parameter int CW     = 2,
  parameter int MAXLAT = 2,
  parameter int LD_LAT = 2,
  parameter int OP_LAT = 1
) (
  input  logic [NSLOT-1:0]              in_vld,
  input  logic [NSLOT-1:0][1:0]         in_unit,
  input  logic [NSLOT-1:0][RW-1:0]      in_dst,
  input  logic [NSLOT-1:0][RW-1:0]      in_srca,
  input  logic [NSLOT-1:0][RW-1:0]      in_srcb,
  input  logic [NREG-1:0]               rdy,
  input  logic [MAXLAT:1][1:0]          book,
  output logic [NSLOT-1:0]              gnt,
  output logic [NSLOT-1:0][NUNIT-1:0]   unit_oh,
  output logic [NSLOT-1:0][CW-1:0]      glat,
  output logic                          stall
);

  logic [NSLOT-1:0] live, regs_ok, port_ok;
  logic             pair_dep, pair_unit;
  logic [1:0]       due1;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign glat[s]    = (in_unit[s] == U_LOAD) ? CW'(LD_LAT) : CW'(OP_LAT);
    assign regs_ok[s] = rdy[in_srca[s]] && rdy[in_srcb[s]] && rdy[in_dst[s]];
    assign unit_oh[s] = gnt[s] ? (NUNIT'(1) << in_unit[s]) : '0;
  end

  // slot 1 only exists behind a valid slot 0
  assign live[0] = in_vld[0];
  assign live[1] = in_vld[0] && in_vld[1];

  assign pair_dep  = (in_srca[1] == in_dst[0]) || (in_srcb[1] == in_dst[0])
                  || (in_dst[1] == in_dst[0]);
  assign pair_unit = (in_unit[1] == in_unit[0]);

  assign due1       = book[glat[1]] + 2'(glat[1] == glat[0]);
  assign port_ok[0] = (book[glat[0]] < 2'd2);
  assign port_ok[1] = (due1 < 2'd2);

  always_comb begin
    gnt[0] = live[0] && regs_ok[0] && port_ok[0];
    gnt[1] = live[1] && gnt[0] && regs_ok[1] && port_ok[1]
          && !pair_dep && !pair_unit;
  end

  assign stall = |(live & ~gnt);

endmodule

// File: rtl/sched_dual_issue.sv
module sched_dual_issue
  import sched_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int LD_LAT = 2,
  parameter int OP_LAT = 1,
  localparam int RW    = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         in_vld,
  input  logic [1:0][1:0]    in_unit,
  input  logic [1:0][RW-1:0] in_dst,
  input  logic [1:0][RW-1:0] in_srca,
  input  logic [1:0][RW-1:0] in_srcb,
  output logic [1:0]         iss_gnt,
  output logic [1:0][3:0]    iss_unit,
  output logic               iss_stall,
  output logic [1:0]         wb_vld,
  output logic [1:0][RW-1:0] wb_reg
);

  localparam int MAXLAT = (LD_LAT > OP_LAT) ? LD_LAT : OP_LAT;
  localparam int CW     = $clog2(MAXLAT + 1);

  logic [NREG-1:0]          reg_rdy, wb_req;
  logic [MAXLAT:1][1:0]     due_book;
  logic [NSLOT-1:0][CW-1:0] g_lat, g_cnt;

  sched_issue_ctl #(
    .NREG(NREG), .RW(RW), .CW(CW), .MAXLAT(MAXLAT),
    .LD_LAT(LD_LAT), .OP_LAT(OP_LAT)
  ) u_ctl (
    .in_vld  (in_vld),
    .in_unit (in_unit),
    .in_dst  (in_dst),
    .in_srca (in_srca),
    .in_srcb (in_srcb),
    .rdy     (reg_rdy),
    .book    (due_book),
    .gnt     (iss_gnt),
    .unit_oh (iss_unit),
    .glat    (g_lat),
    .stall   (iss_stall)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_cnt_ld
    assign g_cnt[s] = g_lat[s] - CW'(1);
  end

  sched_scoreboard #(.NREG(NREG), .RW(RW), .CW(CW)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (iss_gnt),
    .set_reg (in_dst),
    .set_cnt (g_cnt),
    .rdy     (reg_rdy),
    .done    (wb_req)
  );

  sched_wb_book #(.MAXLAT(MAXLAT), .CW(CW)) u_book (
    .clk   (clk),
    .rst_n (rst_n),
    .gnt   (iss_gnt),
    .glat  (g_lat),
    .book  (due_book)
  );

  sched_wb_pick #(.NREG(NREG), .RW(RW)) u_pick (
    .done   (wb_req),
    .wb_vld (wb_vld),
    .wb_reg (wb_reg)
  );

endmodule

// File: rtl/sched_dual_issue_chk.sv
module sched_dual_issue_chk #(
  parameter int NREG   = 16,
  parameter int RW     = 4,
  parameter int LD_LAT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         in_vld,
  input logic [1:0][1:0]    in_unit,
  input logic [1:0][RW-1:0] in_dst,
  input logic [1:0][RW-1:0] in_srca,
  input logic [1:0][RW-1:0] in_srcb,
  input logic [1:0]         iss_gnt,
  input logic [1:0][3:0]    iss_unit,
  input logic [1:0]         wb_vld,
  input logic [1:0][RW-1:0] wb_reg,
  input logic [NREG-1:0]    rdy,
  input logic [NREG-1:0]    wbreq
);

  p_sel0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_gnt[0] |-> $onehot(iss_unit[0]) && iss_unit[0][in_unit[0]]);
  p_sel1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_gnt[1] |-> iss_unit[1] == 4'b0000);
  p_src_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_gnt[0] |-> rdy[in_srca[0]] && rdy[in_srcb[0]] && rdy[in_dst[0]]);
  p_pair_dep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    &iss_gnt |-> in_srca[1] != in_dst[0] && in_srcb[1] != in_dst[0]
              && in_dst[1] != in_dst[0]);
  p_unit_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    &iss_gnt |-> iss_unit[0] != iss_unit[1]);
  p_in_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_gnt[1] |-> iss_gnt[0]);
  p_wb_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wbreq) <= 2);
  p_wb_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_vld[1] |-> wb_vld[0] && wb_reg[0] < wb_reg[1]);
  p_load_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (LD_LAT > 1) && iss_gnt[0] && in_unit[0] == 2'd3 |=> !rdy[$past(in_dst[0])]);
  p_lone_slot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld[0] |-> iss_gnt == 2'b00);

endmodule

bind sched_dual_issue sched_dual_issue_chk #(
  .NREG(NREG), .RW(RW), .LD_LAT(LD_LAT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .in_unit  (in_unit),
  .in_dst   (in_dst),
  .in_srca  (in_srca),
  .in_srcb  (in_srcb),
  .iss_gnt  (iss_gnt),
  .iss_unit (iss_unit),
  .wb_vld   (wb_vld),
  .wb_reg   (wb_reg),
  .rdy      (reg_rdy),
  .wbreq    (wb_req)
);

// File: tb/test_sched_dual_issue.sv
module test_sched_dual_issue;

  localparam int CLK_P = 10;
  localparam int NREG  = 16;
  localparam int RW    = 4;
  localparam int QMAX  = 1024;
  localparam int WDOG  = 20000;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [1:0]         in_vld;
  logic [1:0][1:0]    in_unit;
  logic [1:0][RW-1:0] in_dst, in_srca, in_srcb;
  logic [1:0]         iss_gnt;
  logic [1:0][3:0]    iss_unit;
  logic               iss_stall;
  logic [1:0]         wb_vld;
  logic [1:0][RW-1:0] wb_reg;

  sched_dual_issue #(.NREG(NREG)) i_sched_dual_issue (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_unit(in_unit),
    .in_dst(in_dst), .in_srca(in_srca), .in_srcb(in_srcb),
    .iss_gnt(iss_gnt), .iss_unit(iss_unit), .iss_stall(iss_stall),
    .wb_vld(wb_vld), .wb_reg(wb_reg)
  );

  always #(CLK_P / 2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done_flag = 0;
  int p_unit[QMAX], p_d[QMAX], p_a[QMAX], p_b[QMAX], iss_at[QMAX];
  int head = 0, tail = 0;
  int ready_at[NREG];
  int lcg = 12345;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int lat(int u);
    return (u == 3) ? 2 : 1;
  endfunction

  function automatic int due(int t);
    int n = 0;
    for (int r = 0; r < NREG; r++) if (ready_at[r] == t) n++;
    return n;
  endfunction

  function automatic bit ok(int r);
    return ready_at[r] <= cyc;
  endfunction

  task automatic push(int u, int d, int a, int b);
    p_unit[tail] = u; p_d[tail] = d; p_a[tail] = a; p_b[tail] = b;
    iss_at[tail] = -1;
    tail++;
  endtask

  // one clock: drive, predict, compare before the edge, then advance the model
  task automatic step(bit lone);
    bit v0, v1, e0, e1;
    int i0, i1, ew0, ew1, nw, exp_stall;
    i0 = head; i1 = head + 1;
    v0 = !lone && (head < tail);
    v1 = lone ? (head < tail) : (head + 1 < tail);
    if (lone) i1 = head;
    in_vld     = {v1, v0};
    in_unit[0] = 2'(v0 ? p_unit[i0] : 0);
    in_dst[0]  = RW'(v0 ? p_d[i0] : 0);
    in_srca[0] = RW'(v0 ? p_a[i0] : 0);
    in_srcb[0] = RW'(v0 ? p_b[i0] : 0);
    in_unit[1] = 2'(v1 ? p_unit[i1] : 0);
    in_dst[1]  = RW'(v1 ? p_d[i1] : 0);
    in_srca[1] = RW'(v1 ? p_a[i1] : 0);
    in_srcb[1] = RW'(v1 ? p_b[i1] : 0);
    e0 = v0 && ok(p_d[i0]) && ok(p_a[i0]) && ok(p_b[i0])
         && due(cyc + lat(p_unit[i0])) < 2;
    e1 = e0 && v1 && ok(p_d[i1]) && ok(p_a[i1]) && ok(p_b[i1])
         && p_unit[i1] != p_unit[i0] && p_a[i1] != p_d[i0]
         && p_b[i1] != p_d[i0] && p_d[i1] != p_d[i0]
         && due(cyc + lat(p_unit[i1])) + ((lat(p_unit[i1]) == lat(p_unit[i0])) ? 1 : 0) < 2;
    exp_stall = ((v0 && !e0) || (v0 && v1 && !e1)) ? 1 : 0;
    ew0 = -1; ew1 = -1; nw = 0;
    for (int r = 0; r < NREG; r++)
      if (ready_at[r] == cyc) begin
        if (nw == 0) ew0 = r; else if (nw == 1) ew1 = r;
        nw++;
      end
    #(CLK_P / 2 - 2);
    chk("R5 grant slot0", int'(iss_gnt[0]), int'(e0));
    chk("R7 grant slot1", int'(iss_gnt[1]), int'(e1));
    chk("R2 unit slot0", int'(iss_unit[0]), e0 ? (1 << p_unit[i0]) : 0);
    chk("R2 unit slot1", int'(iss_unit[1]), e1 ? (1 << p_unit[i1]) : 0);
    chk("R10 stall", int'(iss_stall), exp_stall);
    chk("R8 wb count", nw, (nw > 2) ? 2 : nw);
    chk("R8 wb port0", wb_vld[0] ? int'(wb_reg[0]) : -1, ew0);
    chk("R8 wb port1", wb_vld[1] ? int'(wb_reg[1]) : -1, ew1);
    if (iss_gnt[0] && v0) iss_at[i0] = cyc;
    if (iss_gnt[1] && v1 && !lone) iss_at[i1] = cyc;
    @(posedge clk);
    if (e0) ready_at[p_d[i0]] = cyc + lat(p_unit[i0]);
    if (e1) ready_at[p_d[i1]] = cyc + lat(p_unit[i1]);
    if (lone) head++;
    else head += int'(e0) + int'(e1);
    cyc++;
    @(negedge clk);
  endtask

  task automatic drain();
    while (head < tail) step(1'b0);
    for (int k = 0; k < 3; k++) step(1'b0);
  endtask

  task automatic rel(string tag, int base, int idx, int exp);
    chk(tag, iss_at[idx] - iss_at[base], exp);
  endtask

  initial begin
    int b;
    for (int r = 0; r < NREG; r++) ready_at[r] = -1;
    rst_n = 1'b0;
    in_vld = '0; in_unit = '0; in_dst = '0; in_srca = '0; in_srcb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset, then first instruction issues at once
    #1;
    chk("R1 no writeback", int'(wb_vld), 0);
    chk("R1 no grant idle", int'(iss_gnt), 0);
    @(negedge clk);
    cyc++;
    b = tail; push(2, 4, 5, 6);
    step(1'b0);
    chk("R1 first issue", int'(iss_at[b] >= 0), 1);
    drain();

    // R11: load, dependent add, subtract on adder, multiply
    b = tail;
    push(3, 1, 2, 2); push(1, 3, 1, 4); push(1, 5, 6, 7); push(0, 8, 9, 10);
    drain();
    rel("R11 add after load", b, b + 1, 2);
    rel("R11 sub", b, b + 2, 3);
    rel("R11 mul", b, b + 3, 3);
    rel("R3 load to use", b, b + 1, 2);

    // R3: single-cycle producer feeds next cycle
    b = tail; push(2, 2, 3, 4); push(1, 5, 2, 2);
    drain();
    rel("R3 alu back to back", b, b + 1, 1);

    // R6: same unit serialises, different units pair
    b = tail; push(0, 1, 2, 3); push(0, 4, 2, 3); push(2, 6, 7, 8); push(1, 9, 7, 8);
    drain();
    rel("R6 mul conflict", b, b + 1, 1);
    rel("R6 mixed pair", b + 1, b + 2, 0);

    // R9: load then two single-cycle ops land on the same completion cycle
    b = tail;
    push(0, 12, 14, 15); push(0, 13, 14, 15); push(3, 1, 2, 2);
    push(1, 3, 4, 5); push(2, 6, 7, 8);
    drain();
    rel("R9 load pairs", b, b + 2, 1);
    rel("R9 first alu", b, b + 3, 2);
    rel("R9 port full", b, b + 4, 3);

    // R4 and R7: destination in flight blocks, younger waits behind it
    b = tail;
    push(3, 1, 2, 2); push(2, 6, 7, 8); push(0, 1, 9, 10); push(1, 11, 12, 13);
    drain();
    rel("R4 pair with load", b, b + 1, 0);
    rel("R4 waw in flight", b, b + 2, 2);
    rel("R7 younger held", b, b + 3, 2);

    // R5: destination clash inside the pair
    b = tail; push(1, 3, 4, 5); push(2, 3, 6, 7);
    drain();
    rel("R5 pair waw", b, b + 1, 1);

    // R12: lone slot 1 is ignored; no writeback follows
    push(1, 5, 6, 7);
    step(1'b1);
    for (int k = 0; k < 3; k++) step(1'b0);
    chk("R12 no write after lone", int'(ready_at[5] >= cyc - 3), 0);

    // mixed stream over a small register set
    for (int n = 0; n < 400; n++) begin
      int u, d, a, c;
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff; u = (lcg >> 8) % 4;
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff; d = (lcg >> 8) % 8;
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff; a = (lcg >> 8) % 8;
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff; c = (lcg >> 8) % 8;
      push(u, d, a, (u == 3) ? a : c);
    end
    drain();

    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule